// File: doc/BRIEF.md
# Video Test Pattern Pixel Generator

This block turns the position of the current pixel inside the active picture into an RGB value. Timing is generated elsewhere: a caller supplies the horizontal and vertical position of each active pixel, a data-enable qualifier, the active width and height and a frame-start pulse. The block returns one registered 24-bit pixel per clock. The pattern comes from a fixed set chosen by a 4-bit code. The set holds solid colors, horizontal and vertical brightness ramps, a custom color, a checkerboard and a four-color band pattern. A color-bar switch can replace any selection with eight vertical bars. All results can be inverted to their complements, and an 18-bit mode limits each channel to its six upper bits.

An auto-scroll sequencer can take over the choice of pattern. It walks through a 16-bit mask of allowed pattern codes and moves on after a programmed number of frames. When it is off, the manual code is used directly and the sequencer follows that code, so scrolling starts from the pattern on display.

Top module: `vtpg_pixel_core`

## Requirements
- R1: While reset is asserted, and on the first clock after reset, `pix_rgb` is 0.
- R2: `pix_rgb` shows the pixel for the inputs sampled at the previous rising clock edge. It is 0 whenever `de` was low at that edge. The word is packed as {R[23:16], G[15:8], B[7:0]}.
- R3: Codes 1 to 5 give solid white FFFFFF, black 000000, red FF0000, green 00FF00 and blue 0000FF. Code 14 gives `cust_rgb` unchanged.
- R4: Codes 6, 7, 8 and 9 are horizontal ramps. Their level is L = floor(hpos*256/act_w), placed on all three channels (6), red only (7), green only (8) or blue only (9). The other channels are 0.
- R5: Codes 10 to 13 are the same four ramps in the same channel order. They use L = floor(vpos*256/act_h).
- R6: With `depth18` set, the ramp level is floor(pos*64/size)*4, and the two lowest bits of every channel of every output are 0.
- R7: With `invert` set, the output is the bitwise complement of the value the pattern would otherwise give. In 18-bit mode the two lowest bits of each channel are still cleared.
- R8: Code 0 is a checkerboard. A pixel is light when bit 0 of hpos XOR bit 0 of vpos is 0, and black otherwise. With `chk_scale` set, bit 3 is used instead, which gives 8x8 squares. The light color is white, or `cust_rgb` when `chk_custom` is set.
- R9: Code 15 is a four-band pattern. The band index is (hcell + vcell) mod 4, where the cells are pixels, or 8x8 blocks when `chk_scale` is set. Index 0..3 gives yellow FFFF00, cyan 00FFFF, blue 0000FF, red FF0000. With `band_rev` set, the index is reversed (3 minus index).
- R10: `bars_en` overrides the selected or scrolled code. The bar index is floor(hpos*8/act_w), and indices 0..7 give white, yellow, cyan, green, magenta, red, blue, black.
- R11: With `scroll_en` set, `pat_sel` is ignored. After every `scroll_frames` rising edges of `frame_start` (0 counts as 1), the pattern moves to the next higher code whose mask bit is set, wrapping from 15 to 0. It holds between those edges.
- R12: With `scroll_en` set and `scroll_mask` all zero, the pattern holds. While `scroll_en` is low, the sequencer follows `pat_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de | input | 1 | Active-pixel qualifier |
| hpos | input | CW (12) | Horizontal position in the active area |
| vpos | input | CW (12) | Vertical position in the active area |
| act_w | input | CW (12) | Active width in pixels |
| act_h | input | CW (12) | Active height in lines |
| pat_sel | input | 4 | Manual pattern code |
| bars_en | input | 1 | Color-bar override |
| invert | input | 1 | Complement the output colors |
| chk_scale | input | 1 | 8x8 cells for checkerboard and bands |
| chk_custom | input | 1 | Custom color as checkerboard light color |
| depth18 | input | 1 | 18-bit mode |
| band_rev | input | 1 | Reverse band order |
| cust_rgb | input | 24 | Custom color {R,G,B} |
| scroll_en | input | 1 | Auto-scroll enable |
| scroll_mask | input | 16 | Allowed pattern codes, bit n = code n |
| scroll_frames | input | FW (8) | Frames per pattern (0 treated as 1) |
| frame_start | input | 1 | Frame-start pulse, counted on its rising edge |
| pix_rgb | output | 24 | Registered pixel {R,G,B} |

## Verification
The position-to-color path has exactly one register, so a pixel result is due one clock after its inputs are sampled. The bench drives on the falling edge and compares on the next falling edge, after one rising edge. A frame-start pulse is first seen at a rising edge, and the sequencer changes pattern on that same edge. The pixel register then needs one more edge. For this reason the scroll checks hold each pulse for one cycle and wait two falling edges before sampling. Ramp and bar expectations are worked out as integer floors from the width and height in the requirements. They are never read from the design.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;

    localparam int NPAT = 16;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    localparam rgb_t C_WHITE   = '{r: 8'hFF, g: 8'hFF, b: 8'hFF};
    localparam rgb_t C_BLACK   = '{r: 8'h00, g: 8'h00, b: 8'h00};
    localparam rgb_t C_RED     = '{r: 8'hFF, g: 8'h00, b: 8'h00};
    localparam rgb_t C_GREEN   = '{r: 8'h00, g: 8'hFF, b: 8'h00};
    localparam rgb_t C_BLUE    = '{r: 8'h00, g: 8'h00, b: 8'hFF};
    localparam rgb_t C_YELLOW  = '{r: 8'hFF, g: 8'hFF, b: 8'h00};
    localparam rgb_t C_CYAN    = '{r: 8'h00, g: 8'hFF, b: 8'hFF};
    localparam rgb_t C_MAGENTA = '{r: 8'hFF, g: 8'h00, b: 8'hFF};

    localparam logic [3:0] P_CHECKER = 4'd0;
    localparam logic [3:0] P_WHITE   = 4'd1;
    localparam logic [3:0] P_BLACK   = 4'd2;
    localparam logic [3:0] P_RED     = 4'd3;
    localparam logic [3:0] P_GREEN   = 4'd4;
    localparam logic [3:0] P_BLUE    = 4'd5;
    localparam logic [3:0] P_HGRAY   = 4'd6;
    localparam logic [3:0] P_HRED    = 4'd7;
    localparam logic [3:0] P_HGREEN  = 4'd8;
    localparam logic [3:0] P_HBLUE   = 4'd9;
    localparam logic [3:0] P_VGRAY   = 4'd10;
    localparam logic [3:0] P_VRED    = 4'd11;
    localparam logic [3:0] P_VGREEN  = 4'd12;
    localparam logic [3:0] P_VBLUE   = 4'd13;
    localparam logic [3:0] P_CUSTOM  = 4'd14;
    localparam logic [3:0] P_BANDS   = 4'd15;

    localparam logic [23:0] MASK18 = 24'hFCFCFC;

endpackage

// File: rtl/vtpg_scroll.sv
module vtpg_scroll
    import vtpg_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scroll_en,
    input  logic [NPAT-1:0] scroll_mask,
    input  logic [FW-1:0]   scroll_frames,
    input  logic            frame_start,
    input  logic [3:0]      pat_sel,
    output logic [3:0]      pat_out
);

    typedef struct packed {
        logic [3:0]    pat;
        logic [FW-1:0] cnt;
        logic          fs_prev;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [3:0]    nxt_pat;
    logic          nxt_found;
    logic [FW-1:0] limit;
    logic          fs_edge;

    // search upward from the current code for the next allowed one
    always_comb begin
        nxt_pat   = seq_q.pat;
        nxt_found = 1'b0;
        for (int k = 1; k <= NPAT; k++) begin
            logic [3:0] cand;
            cand = seq_q.pat + 4'(k);
            if (!nxt_found && scroll_mask[cand]) begin
                nxt_pat   = cand;
                nxt_found = 1'b1;
            end
        end
    end

    always_comb begin
        seq_d         = seq_q;
        seq_d.fs_prev = frame_start;
        fs_edge       = frame_start & ~seq_q.fs_prev;
        limit         = (scroll_frames == '0) ? FW'(1) : scroll_frames;
        if (!scroll_en) begin
            seq_d.pat = pat_sel;
            seq_d.cnt = '0;
        end else if (fs_edge) begin
            if (seq_q.cnt + FW'(1) >= limit) begin
                seq_d.cnt = '0;
                if (nxt_found) begin
                    seq_d.pat = nxt_pat;
                end
            end else begin
                seq_d.cnt = seq_q.cnt + FW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pat_out = scroll_en ? seq_q.pat : pat_sel;

endmodule

// File: rtl/vtpg_color.sv
module vtpg_color
    import vtpg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [CW-1:0] hpos,
    input  logic [CW-1:0] vpos,
    input  logic [CW-1:0] act_w,
    input  logic [CW-1:0] act_h,
    input  logic [3:0]    pat,
    input  logic          bars_en,
    input  logic          invert,
    input  logic          chk_scale,
    input  logic          chk_custom,
    input  logic          depth18,
    input  logic          band_rev,
    input  logic [23:0]   cust_rgb,
    output logic [23:0]   rgb
);

    localparam int NW = CW + 8;
    localparam int BW = CW + 3;

    // evenly spread level of pos across size, saturating at the top level
    function automatic logic [7:0] ramp_level(input logic [CW-1:0] pos,
                                              input logic [CW-1:0] size,
                                              input logic          d18);
        logic [NW-1:0] num;
        logic [NW-1:0] q;
        if (size == '0) begin
            return d18 ? 8'hFC : 8'hFF;
        end
        num = d18 ? {2'b00, pos, 6'b0} : {pos, 8'b0};
        q   = num / {8'b0, size};
        if (d18) begin
            return (q > NW'(63)) ? 8'hFC : {q[5:0], 2'b00};
        end
        return (q > NW'(255)) ? 8'hFF : q[7:0];
    endfunction

    function automatic logic [2:0] bar_index(input logic [CW-1:0] pos,
                                             input logic [CW-1:0] size);
        logic [BW-1:0] q;
        if (size == '0) begin
            return 3'd7;
        end
        q = {pos, 3'b0} / {3'b0, size};
        return (q > BW'(7)) ? 3'd7 : q[2:0];
    endfunction

    rgb_t          base;
    rgb_t          light;
    logic [CW-1:0] hcell;
    logic [CW-1:0] vcell;
    logic [1:0]    band;
    logic [7:0]    hl;
    logic [7:0]    vl;
    logic [23:0]   shaped;

    always_comb begin
        hcell = chk_scale ? (hpos >> 3) : hpos;
        vcell = chk_scale ? (vpos >> 3) : vpos;
        light = chk_custom ? rgb_t'(cust_rgb) : C_WHITE;
        band  = hcell[1:0] + vcell[1:0];
        if (band_rev) begin
            band = 2'd3 - band;
        end
        hl = ramp_level(hpos, act_w, depth18);
        vl = ramp_level(vpos, act_h, depth18);

        unique case (pat)
            P_CHECKER: base = (hcell[0] ^ vcell[0]) ? C_BLACK : light;
            P_WHITE:   base = C_WHITE;
            P_BLACK:   base = C_BLACK;
            P_RED:     base = C_RED;
            P_GREEN:   base = C_GREEN;
            P_BLUE:    base = C_BLUE;
            P_HGRAY:   base = '{r: hl, g: hl, b: hl};
            P_HRED:    base = '{r: hl, g: 8'h00, b: 8'h00};
            P_HGREEN:  base = '{r: 8'h00, g: hl, b: 8'h00};
            P_HBLUE:   base = '{r: 8'h00, g: 8'h00, b: hl};
            P_VGRAY:   base = '{r: vl, g: vl, b: vl};
            P_VRED:    base = '{r: vl, g: 8'h00, b: 8'h00};
            P_VGREEN:  base = '{r: 8'h00, g: vl, b: 8'h00};
            P_VBLUE:   base = '{r: 8'h00, g: 8'h00, b: vl};
            P_CUSTOM:  base = rgb_t'(cust_rgb);
            default: begin
                unique case (band)
                    2'd0:    base = C_YELLOW;
                    2'd1:    base = C_CYAN;
                    2'd2:    base = C_BLUE;
                    default: base = C_RED;
                endcase
            end
        endcase

        if (bars_en) begin
            unique case (bar_index(hpos, act_w))
                3'd0:    base = C_WHITE;
                3'd1:    base = C_YELLOW;
                3'd2:    base = C_CYAN;
                3'd3:    base = C_GREEN;
                3'd4:    base = C_MAGENTA;
                3'd5:    base = C_RED;
                3'd6:    base = C_BLUE;
                default: base = C_BLACK;
            endcase
        end

        shaped = invert ? ~base : base;
        rgb    = depth18 ? (shaped & MASK18) : shaped;
    end

endmodule

// File: rtl/vtpg_pixel_core.sv
module vtpg_pixel_core
    import vtpg_pkg::*;
#(
    parameter int CW = 12,
    parameter int FW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            de,
    input  logic [CW-1:0]   hpos,
    input  logic [CW-1:0]   vpos,
    input  logic [CW-1:0]   act_w,
    input  logic [CW-1:0]   act_h,
    input  logic [3:0]      pat_sel,
    input  logic            bars_en,
    input  logic            invert,
    input  logic            chk_scale,
    input  logic            chk_custom,
    input  logic            depth18,
    input  logic            band_rev,
    input  logic [23:0]     cust_rgb,
    input  logic            scroll_en,
    input  logic [NPAT-1:0] scroll_mask,
    input  logic [FW-1:0]   scroll_frames,
    input  logic            frame_start,
    output logic [23:0]     pix_rgb
);

    typedef struct packed {
        logic [23:0] pix;
    } out_t;

    out_t        out_d, out_q;
    logic [3:0]  eff_pat;
    logic [23:0] color;

    vtpg_scroll #(.FW(FW)) u_scroll (
        .clk          (clk),
        .rst_n        (rst_n),
        .scroll_en    (scroll_en),
        .scroll_mask  (scroll_mask),
        .scroll_frames(scroll_frames),
        .frame_start  (frame_start),
        .pat_sel      (pat_sel),
        .pat_out      (eff_pat)
    );

    vtpg_color #(.CW(CW)) u_color (
        .hpos      (hpos),
        .vpos      (vpos),
        .act_w     (act_w),
        .act_h     (act_h),
        .pat       (eff_pat),
        .bars_en   (bars_en),
        .invert    (invert),
        .chk_scale (chk_scale),
        .chk_custom(chk_custom),
        .depth18   (depth18),
        .band_rev  (band_rev),
        .cust_rgb  (cust_rgb),
        .rgb       (color)
    );

    always_comb begin
        out_d     = out_q;
        out_d.pix = de ? color : 24'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pix_rgb = out_q.pix;

endmodule

// File: rtl/vtpg_checker.sv
module vtpg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        de,
    input logic [3:0]  pat_sel,
    input logic        bars_en,
    input logic        invert,
    input logic        depth18,
    input logic        scroll_en,
    input logic [15:0] scroll_mask,
    input logic        frame_start,
    input logic [3:0]  eff_pat,
    input logic [23:0] pix_rgb
);

    assert_blank_without_de_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !de |=> (pix_rgb == 24'h0)
    );

    assert_low_bits_clear_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        depth18 |=> ((pix_rgb & 24'h030303) == 24'h0)
    );

    assert_solid_white_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (de && !scroll_en && pat_sel == 4'd1 && !bars_en && !invert && !depth18)
        |=> (pix_rgb == 24'hFFFFFF)
    );

    assert_hold_between_frames_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (scroll_en && $past(scroll_en) && !$past(frame_start))
        |-> (eff_pat == $past(eff_pat))
    );

    assert_empty_mask_holds_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        (scroll_en && $past(scroll_en) && $past(scroll_mask) == 16'h0)
        |-> (eff_pat == $past(eff_pat))
    );

endmodule

bind vtpg_pixel_core vtpg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .de         (de),
    .pat_sel    (pat_sel),
    .bars_en    (bars_en),
    .invert     (invert),
    .depth18    (depth18),
    .scroll_en  (scroll_en),
    .scroll_mask(scroll_mask),
    .frame_start(frame_start),
    .eff_pat    (eff_pat),
    .pix_rgb    (pix_rgb)
);

// File: tb/vtpg_pixel_core_test.sv
module vtpg_pixel_core_test;

    localparam int CW = 12;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          de = 1'b0;
    logic [CW-1:0] hpos = '0;
    logic [CW-1:0] vpos = '0;
    logic [CW-1:0] act_w = 12'd100;
    logic [CW-1:0] act_h = 12'd50;
    logic [3:0]    pat_sel = 4'd1;
    logic          bars_en = 1'b0;
    logic          invert = 1'b0;
    logic          chk_scale = 1'b0;
    logic          chk_custom = 1'b0;
    logic          depth18 = 1'b0;
    logic          band_rev = 1'b0;
    logic [23:0]   cust_rgb = 24'h123456;
    logic          scroll_en = 1'b0;
    logic [15:0]   scroll_mask = '0;
    logic [FW-1:0] scroll_frames = '0;
    logic          frame_start = 1'b0;
    logic [23:0]   pix_rgb;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    vtpg_pixel_core #(.CW(CW), .FW(FW)) uut (
        .clk(clk), .rst_n(rst_n), .de(de), .hpos(hpos), .vpos(vpos),
        .act_w(act_w), .act_h(act_h), .pat_sel(pat_sel), .bars_en(bars_en),
        .invert(invert), .chk_scale(chk_scale), .chk_custom(chk_custom),
        .depth18(depth18), .band_rev(band_rev), .cust_rgb(cust_rgb),
        .scroll_en(scroll_en), .scroll_mask(scroll_mask),
        .scroll_frames(scroll_frames), .frame_start(frame_start),
        .pix_rgb(pix_rgb)
    );

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: pix_rgb=%06h expected %06h", req, got, exp);
        end
    endtask

    // drive a pixel on a falling edge and compare one rising edge later
    task automatic pixel(input logic [3:0] p, input int h, input int v,
                         input string req, input logic [23:0] exp);
        pat_sel = p;
        hpos    = CW'(h);
        vpos    = CW'(v);
        de      = 1'b1;
        @(negedge clk);
        check(req, pix_rgb, exp);
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 during reset", pix_rgb, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 after release", pix_rgb, 24'h0);
    endtask

    task automatic t_solid();
        pixel(4'd1, 3, 3, "R3 white", 24'hFFFFFF);
        pixel(4'd2, 3, 3, "R3 black", 24'h000000);
        pixel(4'd3, 3, 3, "R3 red", 24'hFF0000);
        pixel(4'd4, 3, 3, "R3 green", 24'h00FF00);
        pixel(4'd5, 3, 3, "R3 blue", 24'h0000FF);
        pixel(4'd14, 3, 3, "R3 custom", 24'h123456);
    endtask

    task automatic t_de();
        pat_sel = 4'd1;
        de      = 1'b0;
        @(negedge clk);
        check("R2 de low blanks", pix_rgb, 24'h0);
        de = 1'b1;
        check("R2 no change before edge", pix_rgb, 24'h0);
        @(negedge clk);
        check("R2 one cycle latency", pix_rgb, 24'hFFFFFF);
    endtask

    task automatic t_ramps();
        pixel(4'd6, 50, 0, "R4 gray mid", 24'h808080);
        pixel(4'd7, 99, 0, "R4 red end", 24'hFD0000);
        pixel(4'd8, 0, 0, "R4 green start", 24'h000000);
        pixel(4'd9, 25, 0, "R4 blue quarter", 24'h000040);
        pixel(4'd10, 77, 25, "R5 gray mid", 24'h808080);
        pixel(4'd13, 0, 49, "R5 blue end", 24'h0000FA);
        pixel(4'd11, 0, 10, "R5 red 10", 24'h330000);
    endtask

    task automatic t_depth18();
        depth18 = 1'b1;
        pixel(4'd6, 50, 0, "R6 gray mid", 24'h808080);
        pixel(4'd7, 99, 0, "R6 red end", 24'hFC0000);
        pixel(4'd14, 0, 0, "R6 custom masked", 24'h103454);
        pixel(4'd1, 0, 0, "R6 white masked", 24'hFCFCFC);
        depth18 = 1'b0;
    endtask

    task automatic t_invert();
        invert = 1'b1;
        pixel(4'd3, 0, 0, "R7 red to cyan", 24'h00FFFF);
        pixel(4'd7, 99, 0, "R7 ramp inverted", 24'h02FFFF);
        pixel(4'd14, 0, 0, "R7 custom inverted", 24'hEDCBA9);
        depth18 = 1'b1;
        pixel(4'd2, 0, 0, "R7 inverted 18-bit", 24'hFCFCFC);
        depth18 = 1'b0;
        invert  = 1'b0;
    endtask

    task automatic t_checker();
        pixel(4'd0, 0, 0, "R8 origin light", 24'hFFFFFF);
        pixel(4'd0, 1, 0, "R8 next dark", 24'h000000);
        pixel(4'd0, 1, 1, "R8 diagonal light", 24'hFFFFFF);
        chk_scale = 1'b1;
        pixel(4'd0, 7, 0, "R8 scaled same cell", 24'hFFFFFF);
        pixel(4'd0, 8, 0, "R8 scaled next cell", 24'h000000);
        pixel(4'd0, 8, 9, "R8 scaled diagonal", 24'hFFFFFF);
        chk_scale  = 1'b0;
        chk_custom = 1'b1;
        pixel(4'd0, 0, 0, "R8 custom light", 24'h123456);
        pixel(4'd0, 0, 1, "R8 custom dark", 24'h000000);
        chk_custom = 1'b0;
    endtask

    task automatic t_bands();
        pixel(4'd15, 0, 0, "R9 band yellow", 24'hFFFF00);
        pixel(4'd15, 1, 0, "R9 band cyan", 24'h00FFFF);
        pixel(4'd15, 2, 0, "R9 band blue", 24'h0000FF);
        pixel(4'd15, 3, 0, "R9 band red", 24'hFF0000);
        pixel(4'd15, 0, 1, "R9 next row cyan", 24'h00FFFF);
        band_rev = 1'b1;
        pixel(4'd15, 0, 0, "R9 reversed red", 24'hFF0000);
        pixel(4'd15, 3, 0, "R9 reversed yellow", 24'hFFFF00);
        band_rev  = 1'b0;
        chk_scale = 1'b1;
        pixel(4'd15, 8, 0, "R9 scaled cyan", 24'h00FFFF);
        chk_scale = 1'b0;
    endtask

    task automatic t_bars();
        bars_en = 1'b1;
        pixel(4'd1, 0, 0, "R10 bar white", 24'hFFFFFF);
        pixel(4'd1, 13, 0, "R10 bar yellow", 24'hFFFF00);
        pixel(4'd1, 60, 0, "R10 bar magenta", 24'hFF00FF);
        pixel(4'd1, 99, 0, "R10 bar black", 24'h000000);
        bars_en = 1'b0;
    endtask

    task automatic t_scroll();
        pat_sel       = 4'd1;
        scroll_mask   = 16'h002A;
        scroll_frames = 8'd2;
        de            = 1'b1;
        @(negedge clk);
        scroll_en = 1'b1;
        pat_sel   = 4'd4;
        @(negedge clk);
        @(negedge clk);
        check("R11 select ignored", pix_rgb, 24'hFFFFFF);
        pulse_frame();
        check("R11 one frame holds", pix_rgb, 24'hFFFFFF);
        pulse_frame();
        check("R11 advance to red", pix_rgb, 24'hFF0000);
        pulse_frame();
        pulse_frame();
        check("R11 skip to blue", pix_rgb, 24'h0000FF);
        pulse_frame();
        pulse_frame();
        check("R11 wrap to white", pix_rgb, 24'hFFFFFF);
        scroll_mask = 16'h0000;
        pulse_frame();
        pulse_frame();
        check("R12 empty mask holds", pix_rgb, 24'hFFFFFF);
        scroll_mask   = 16'h0004;
        scroll_frames = 8'd0;
        pulse_frame();
        check("R11 zero frames counts as one", pix_rgb, 24'h000000);
        scroll_en = 1'b0;
        pat_sel   = 4'd5;
        @(negedge clk);
        check("R12 manual after disable", pix_rgb, 24'h0000FF);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_de();
        t_solid();
        t_ramps();
        t_depth18();
        t_invert();
        t_checker();
        t_bands();
        t_bars();
        t_scroll();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule